// File: doc/BRIEF.md
# Programmable Memory Bank Address Decoder

This block turns a 26-bit byte address (a 64 MB space) into a chip select. It serves a small set of memory banks, one external I/O region split into four sub-banks, and one special-function-register (SFR) region. Each memory bank is a window whose lower and upper limits are held as 10-bit page pointers in 64 KB units. A bank covers every address whose upper ten bits lie at or above its base pointer and below its end pointer. The I/O region is one 64 KB page at a movable base pointer. Its four 16 KB quarters each drive their own select. The SFR region is one 64 KB page.

Software sets the map through a single write port. An index chooses the target, and a base and an end value are written together. Decoding is purely combinational from the address. A pointer write changes the map from the next rising clock edge. After reset only the boot bank (the lower 32 MB) and the SFR page are mapped. The block also watches the programmed map. It raises an error flag whenever two non-empty windows share any address.

Top module: `addr_bank_decoder`

## Requirements
- R1: With `addr_valid` high, memory bank i drives `bank_cs[i]` for an address whose bits [25:16] lie in [base_i, end_i): the first selected byte is base_i×64K and the last is end_i×64K − 1.
- R2: A memory bank whose end pointer is less than or equal to its base pointer never drives its select, whatever the address.
- R3: After synchronous active-low reset, bank 0 has base 0x000 and end 0x200, so 0x0000000..0x1FFFFFF select bank 0 and 0x2000000 misses. All other bank pointers and the I/O pointer are 0. The SFR pointer is 0x3FF, so 0x3FF0000..0x3FFFFFF select the SFR region. The overlap flag is low.
- R4: When the I/O pointer P is non-zero, addresses with bits [25:16] equal to P select the I/O region. `io_cs[k]` is driven for k equal to bits [15:14], so each sub-bank spans 16 KB and sub-bank k starts at P×64K + k×16K. An I/O pointer of 0 leaves the region unmapped.
- R5: When an address falls in more than one window, the SFR region wins over any memory bank, a lower-numbered bank wins over a higher one, and any memory bank wins over the I/O region.
- R6: With `addr_valid` high and no window matching, `miss` is high and every chip select is low.
- R7: With `addr_valid` low, every chip select and `miss` are low.
- R8: A write with `wr_en` high and `wr_idx` = i (0..3) loads bank i's base from `wr_base` and its end from `wr_end`. Index 4 loads the I/O pointer from `wr_base`. Index 5 loads the SFR pointer from `wr_base`. The decode uses the old map up to the rising edge that takes the write and the new map after it.
- R9: A write with `wr_idx` 6 or 7 changes no pointer.
- R10: `ovl_err` is high exactly while two non-empty windows share an address. The windows checked are the memory banks with end > base, the I/O page when its pointer is non-zero, and the SFR page. The flag follows the map, so it changes after the edge that takes a write.
- R11: At most one of `bank_cs`, `io_cs`, `sfr_cs` and `miss` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pointer registers |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 26 | Byte address to decode |
| addr_valid | input | 1 | Address qualifier; outputs stay low while it is low |
| wr_en | input | 1 | Pointer write strobe |
| wr_idx | input | 3 | Write target: 0..3 bank, 4 I/O, 5 SFR, 6..7 none |
| wr_base | input | 10 | Base (or page) pointer value to write |
| wr_end | input | 10 | End pointer value (banks only) |
| bank_cs | output | 4 | One select per memory bank |
| io_cs | output | 4 | One select per 16 KB I/O sub-bank |
| sfr_cs | output | 1 | SFR region select |
| miss | output | 1 | Valid address that no window claims |
| ovl_err | output | 1 | Two programmed windows intersect |

## Verification
The two functions that can fall in the same cycle are a pointer write and the combinational decode of an address that the write is about to remap. The bench sets `wr_en` together with an address inside the new window. It first checks, before the clock edge, that the address still misses under the old map. It then checks, just after the edge, that the same address now selects the rewritten bank. Overlap and priority are also provoked together. Windows are laid on top of one another, and the bench checks both the raised error flag and which single select wins.

// File: rtl/adec_pkg.sv
// Package: shared defaults and the winner-kind type for the address decoder.
// Assumes pointers are page numbers of 2**ADEC_SHIFT bytes.
package adec_pkg;

    localparam int unsigned ADEC_ADDR_W   = 26;     // 64 MB byte space
    localparam int unsigned ADEC_SHIFT    = 16;     // page size 64 KB
    localparam int unsigned ADEC_NBANK    = 4;      // programmable memory banks
    localparam int unsigned ADEC_IO_SUBS  = 4;      // I/O sub-banks per page
    localparam int unsigned ADEC_BOOT_END = 'h200;  // boot bank end pointer at reset
    localparam int unsigned ADEC_SFR_PTR  = 'h3FF;  // SFR page pointer at reset

    // Which kind of window claimed the current address.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SFR  = 2'd1,
        WIN_BANK = 2'd2,
        WIN_IO   = 2'd3
    } win_kind_e;

endpackage

// File: rtl/adec_ptr_regs.sv
// Module: pointer register file of the decoder.
// Holds base/end pointers per bank, the I/O page pointer and the SFR page
// pointer. One write port; out-of-range indices are dropped.
// Assumes synchronous active-low reset.
module adec_ptr_regs #(
    parameter int unsigned NBANK    = 4,
    parameter int unsigned PTR_W    = 10,
    parameter int unsigned IDX_W    = 3,
    parameter int unsigned BOOT_END = 'h200,
    parameter int unsigned SFR_RST  = 'h3FF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [PTR_W-1:0]            wr_base,
    input  logic [PTR_W-1:0]            wr_end,
    output logic [NBANK-1:0][PTR_W-1:0] bank_base,
    output logic [NBANK-1:0][PTR_W-1:0] bank_end,
    output logic [PTR_W-1:0]            io_base,
    output logic [PTR_W-1:0]            sfr_base
);

    localparam logic [PTR_W-1:0] BOOT_END_P = PTR_W'(BOOT_END);
    localparam logic [PTR_W-1:0] SFR_RST_P  = PTR_W'(SFR_RST);
    localparam logic [IDX_W-1:0] IDX_IO     = IDX_W'(NBANK);
    localparam logic [IDX_W-1:0] IDX_SFR    = IDX_W'(NBANK + 1);

    // Bank pointers: reset map has only bank 0 live, writes by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBANK; i++) begin
                bank_base[i] <= '0;
                bank_end[i]  <= (i == 0) ? BOOT_END_P : '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NBANK; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    bank_base[i] <= wr_base;
                    bank_end[i]  <= wr_end;
                end
            end
        end
    end

    // I/O page pointer: cleared at reset (region unmapped).
    always_ff @(posedge clk) begin
        if (!rst_n)
            io_base <= '0;
        else if (wr_en && wr_idx == IDX_IO)
            io_base <= wr_base;
    end

    // SFR page pointer: reset to top page of the space.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sfr_base <= SFR_RST_P;
        else if (wr_en && wr_idx == IDX_SFR)
            sfr_base <= wr_base;
    end

    // Writes to a bank land on the following edge (R8).
    for (genvar g = 0; g < NBANK; g++) begin : g_wr_chk
        assert_bank_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=>
                (bank_base[g] == $past(wr_base) && bank_end[g] == $past(wr_end)));
    end

    // Indices beyond the SFR slot touch nothing (R9).
    assert_bad_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > IDX_SFR) |=>
            ($stable(bank_base) && $stable(bank_end) && $stable(io_base) && $stable(sfr_base)));

endmodule

// File: rtl/adec_window_match.sv
// Module: raw window comparison.
// Flags every window that contains the address page, without priority.
// Assumes half-open bank windows [base, end) in page units; an I/O pointer
// of zero means the I/O page is unmapped.
module adec_window_match #(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned SHIFT  = 16,
    parameter int unsigned SUB_W  = 2,
    parameter int unsigned PTR_W  = ADDR_W - SHIFT
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NBANK-1:0][PTR_W-1:0] bank_base,
    input  logic [NBANK-1:0][PTR_W-1:0] bank_end,
    input  logic [PTR_W-1:0]            io_base,
    input  logic [PTR_W-1:0]            sfr_base,
    output logic [NBANK-1:0]            bank_hit,
    output logic                        io_hit,
    output logic                        sfr_hit,
    output logic [SUB_W-1:0]            io_sub
);

    localparam int unsigned LOW_W = SHIFT - SUB_W;

    logic [PTR_W-1:0] page;
    logic             unused_low;

    assign page       = addr[ADDR_W-1:SHIFT];
    assign io_sub     = addr[SHIFT-1 -: SUB_W];
    assign unused_low = ^addr[LOW_W-1:0];

    // One range comparator pair per bank; empty ranges never match.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign bank_hit[g] = (page >= bank_base[g]) && (page < bank_end[g]);
    end

    // Single-page regions.
    assign io_hit  = (io_base != '0) && (page == io_base);
    assign sfr_hit = (page == sfr_base);

endmodule

// File: rtl/adec_overlap.sv
// Module: overlap detector over the programmed map.
// Every live window is reduced to a half-open page span; each pair of spans
// is compared. Purely combinational from the register outputs.
// Assumes empty banks (end <= base) and a zero I/O pointer are not live.
module adec_overlap #(
    parameter int unsigned NBANK = 4,
    parameter int unsigned PTR_W = 10
) (
    input  logic [NBANK-1:0][PTR_W-1:0] bank_base,
    input  logic [NBANK-1:0][PTR_W-1:0] bank_end,
    input  logic [PTR_W-1:0]            io_base,
    input  logic [PTR_W-1:0]            sfr_base,
    output logic                        ovl
);

    localparam int unsigned NW    = NBANK + 2;
    localparam int unsigned SPAN_W = PTR_W + 1;
    localparam int unsigned W_IO  = NBANK;
    localparam int unsigned W_SFR = NBANK + 1;

    logic [NW-1:0][SPAN_W-1:0] sp_lo;
    logic [NW-1:0][SPAN_W-1:0] sp_hi;
    logic [NW-1:0]             live;

    // Build the span list: banks, then I/O page, then SFR page.
    always_comb begin
        for (int i = 0; i < NBANK; i++) begin
            sp_lo[i] = {1'b0, bank_base[i]};
            sp_hi[i] = {1'b0, bank_end[i]};
            live[i]  = bank_end[i] > bank_base[i];
        end
        sp_lo[W_IO]  = {1'b0, io_base};
        sp_hi[W_IO]  = {1'b0, io_base} + SPAN_W'(1);
        live[W_IO]   = io_base != '0;
        sp_lo[W_SFR] = {1'b0, sfr_base};
        sp_hi[W_SFR] = {1'b0, sfr_base} + SPAN_W'(1);
        live[W_SFR]  = 1'b1;
    end

    // Pairwise intersection test, OR-reduced.
    always_comb begin
        ovl = 1'b0;
        for (int i = 0; i < NW; i++) begin
            for (int j = i + 1; j < NW; j++) begin
                if (live[i] && live[j] && (sp_lo[i] < sp_hi[j]) && (sp_lo[j] < sp_hi[i]))
                    ovl = 1'b1;
            end
        end
    end

endmodule

// File: rtl/adec_priority.sv
// Module: priority resolver for the decoder.
// Picks a single winner: SFR, then lowest bank, then I/O; otherwise miss.
// Assumes raw hit flags from adec_window_match.
module adec_priority
    import adec_pkg::*;
#(
    parameter int unsigned NBANK = 4,
    parameter int unsigned SUBS  = 4,
    parameter int unsigned SUB_W = 2
) (
    input  logic             addr_valid,
    input  logic [NBANK-1:0] bank_hit,
    input  logic             io_hit,
    input  logic             sfr_hit,
    input  logic [SUB_W-1:0] io_sub,
    output logic [NBANK-1:0] bank_cs,
    output logic [SUBS-1:0]  io_cs,
    output logic             sfr_cs,
    output logic             miss
);

    win_kind_e        kind;
    logic [NBANK-1:0] low_bank;

    // Isolate the lowest set hit bit.
    assign low_bank = bank_hit & (~bank_hit + NBANK'(1));

    // Choose the winning window kind.
    always_comb begin
        if (!addr_valid)     kind = WIN_NONE;
        else if (sfr_hit)    kind = WIN_SFR;
        else if (|bank_hit)  kind = WIN_BANK;
        else if (io_hit)     kind = WIN_IO;
        else                 kind = WIN_NONE;
    end

    // Drive the selects from the winner.
    always_comb begin
        bank_cs = (kind == WIN_BANK) ? low_bank : '0;
        sfr_cs  = (kind == WIN_SFR);
        for (int k = 0; k < SUBS; k++)
            io_cs[k] = (kind == WIN_IO) && (io_sub == SUB_W'(k));
        miss    = addr_valid && (kind == WIN_NONE);
    end

endmodule

// File: rtl/addr_bank_decoder.sv
// Module: programmable memory bank address decoder (top).
// Decodes a byte address into bank, I/O sub-bank and SFR selects from a
// register-programmed map and flags intersecting windows.
// Assumes synchronous active-low reset; decode is combinational.
module addr_bank_decoder
    import adec_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADEC_ADDR_W,
    parameter int unsigned SHIFT    = ADEC_SHIFT,
    parameter int unsigned NBANK    = ADEC_NBANK,
    parameter int unsigned IO_SUBS  = ADEC_IO_SUBS,
    parameter int unsigned BOOT_END = ADEC_BOOT_END,
    parameter int unsigned SFR_RST  = ADEC_SFR_PTR,
    localparam int unsigned PTR_W   = ADDR_W - SHIFT,
    localparam int unsigned IDX_W   = $clog2(NBANK + 2),
    localparam int unsigned SUB_W   = $clog2(IO_SUBS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               addr_valid,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PTR_W-1:0]   wr_base,
    input  logic [PTR_W-1:0]   wr_end,
    output logic [NBANK-1:0]   bank_cs,
    output logic [IO_SUBS-1:0] io_cs,
    output logic               sfr_cs,
    output logic               miss,
    output logic               ovl_err
);

    logic [NBANK-1:0][PTR_W-1:0] bank_base;
    logic [NBANK-1:0][PTR_W-1:0] bank_end;
    logic [PTR_W-1:0]            io_base;
    logic [PTR_W-1:0]            sfr_base;
    logic [NBANK-1:0]            bank_hit;
    logic                        io_hit;
    logic                        sfr_hit;
    logic [SUB_W-1:0]            io_sub;

    adec_ptr_regs #(
        .NBANK(NBANK), .PTR_W(PTR_W), .IDX_W(IDX_W),
        .BOOT_END(BOOT_END), .SFR_RST(SFR_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_end(wr_end),
        .bank_base(bank_base), .bank_end(bank_end),
        .io_base(io_base), .sfr_base(sfr_base)
    );

    adec_window_match #(
        .NBANK(NBANK), .ADDR_W(ADDR_W), .SHIFT(SHIFT), .SUB_W(SUB_W), .PTR_W(PTR_W)
    ) u_match (
        .addr(addr),
        .bank_base(bank_base), .bank_end(bank_end),
        .io_base(io_base), .sfr_base(sfr_base),
        .bank_hit(bank_hit), .io_hit(io_hit), .sfr_hit(sfr_hit), .io_sub(io_sub)
    );

    adec_priority #(
        .NBANK(NBANK), .SUBS(IO_SUBS), .SUB_W(SUB_W)
    ) u_prio (
        .addr_valid(addr_valid),
        .bank_hit(bank_hit), .io_hit(io_hit), .sfr_hit(sfr_hit), .io_sub(io_sub),
        .bank_cs(bank_cs), .io_cs(io_cs), .sfr_cs(sfr_cs), .miss(miss)
    );

    adec_overlap #(
        .NBANK(NBANK), .PTR_W(PTR_W)
    ) u_ovl (
        .bank_base(bank_base), .bank_end(bank_end),
        .io_base(io_base), .sfr_base(sfr_base),
        .ovl(ovl_err)
    );

    // ---------------- assertions ----------------

    // At most one output of the select group is high (R11).
    assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_cs, io_cs, sfr_cs, miss}));

    // Invalid address drives nothing (R7).
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> ({bank_cs, io_cs, sfr_cs, miss} == '0));

    // SFR page always wins when addressed (R5).
    assert_sfr_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr[ADDR_W-1:SHIFT] == sfr_base) |-> sfr_cs);

    // A miss never lands on the SFR page (R6).
    assert_miss_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (addr[ADDR_W-1:SHIFT] != sfr_base));

    // I/O select matches the page and quarter of the address (R4).
    assert_io_quarter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_cs) |-> (addr[ADDR_W-1:SHIFT] == io_base &&
                      io_cs == (IO_SUBS'(1) << addr[SHIFT-1 -: SUB_W])));

    // Overlap flag only moves after a write (R10).
    assert_ovl_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ovl_err));

    // Empty banks are never selected; selected banks hold the address (R2, R1).
    for (genvar g = 0; g < NBANK; g++) begin : g_bank_chk
        assert_empty_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
            bank_cs[g] |-> (bank_end[g] > bank_base[g]));
        assert_bank_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            bank_cs[g] |-> (addr[ADDR_W-1:SHIFT] >= bank_base[g] &&
                            addr[ADDR_W-1:SHIFT] <  bank_end[g]));
    end

endmodule

// File: tb/sim_addr_bank_decoder.sv
// Directed bench for addr_bank_decoder: one task per scenario.
module sim_addr_bank_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [25:0] addr = '0;
    logic        addr_valid = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [9:0]  wr_base = '0;
    logic [9:0]  wr_end = '0;
    logic [3:0]  bank_cs;
    logic [3:0]  io_cs;
    logic        sfr_cs;
    logic        miss;
    logic        ovl_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    addr_bank_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_end(wr_end),
        .bank_cs(bank_cs), .io_cs(io_cs), .sfr_cs(sfr_cs), .miss(miss),
        .ovl_err(ovl_err)
    );

    // Compare the select group with an expectation.
    task automatic expect_dec(input logic [3:0] eb, input logic [3:0] ei,
                              input logic es, input logic em, input string tag);
        logic [9:0] act;
        logic [9:0] exp;
        act = {em ^ em ^ miss, sfr_cs, io_cs, bank_cs};
        exp = {em, es, ei, eb};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s addr=%h actual={miss,sfr,io,bank}=%b expected=%b",
                     tag, addr, act, exp);
        end
    endtask

    // Compare the overlap flag.
    task automatic expect_ovl(input logic e, input string tag);
        n_checks++;
        if (ovl_err !== e) begin
            n_fails++;
            $display("FAIL %s ovl_err actual=%b expected=%b", tag, ovl_err, e);
        end
    endtask

    // Present a valid address and check the decode.
    task automatic probe(input logic [25:0] a, input logic [3:0] eb, input logic [3:0] ei,
                         input logic es, input logic em, input string tag);
        @(negedge clk);
        addr = a;
        addr_valid = 1'b1;
        #1;
        expect_dec(eb, ei, es, em, tag);
    endtask

    // One pointer write, taken at the next rising edge.
    task automatic write_ptr(input logic [2:0] idx, input logic [9:0] b, input logic [9:0] e);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_base = b; wr_end = e;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R3 reset map and R1 window edges.
    task automatic t_reset_map();
        #1;
        expect_ovl(1'b0, "R3 overlap clear after reset");
        probe(26'h0000000, 4'b0001, 4'b0, 1'b0, 1'b0, "R3 boot bank first byte");
        probe(26'h1FFFFFF, 4'b0001, 4'b0, 1'b0, 1'b0, "R3 R1 boot bank last byte");
        probe(26'h2000000, 4'b0000, 4'b0, 1'b0, 1'b1, "R3 R1 end is exclusive");
        probe(26'h3FF0000, 4'b0000, 4'b0, 1'b1, 1'b0, "R3 SFR page start");
        probe(26'h3FFFFFF, 4'b0000, 4'b0, 1'b1, 1'b0, "R3 SFR page end");
        probe(26'h3FEFFFF, 4'b0000, 4'b0, 1'b0, 1'b1, "R6 below SFR page misses");
    endtask

    // R8 program a bank and R1 its edges.
    task automatic t_program_bank();
        write_ptr(3'd1, 10'h200, 10'h240);
        probe(26'h2000000, 4'b0010, 4'b0, 1'b0, 1'b0, "R8 R1 bank1 first byte");
        probe(26'h23FFFFF, 4'b0010, 4'b0, 1'b0, 1'b0, "R1 bank1 last byte");
        probe(26'h2400000, 4'b0000, 4'b0, 1'b0, 1'b1, "R1 R6 bank1 end exclusive");
        expect_ovl(1'b0, "R10 adjacent banks do not overlap");
    endtask

    // R2 empty banks.
    task automatic t_empty_bank();
        write_ptr(3'd2, 10'h300, 10'h300);
        probe(26'h3000000, 4'b0000, 4'b0, 1'b0, 1'b1, "R2 end equal base is empty");
        write_ptr(3'd2, 10'h300, 10'h2F0);
        probe(26'h2F80000, 4'b0000, 4'b0, 1'b0, 1'b1, "R2 end below base is empty");
        expect_ovl(1'b0, "R2 R10 empty bank never overlaps");
    endtask

    // R4 I/O sub-banks.
    task automatic t_io_region();
        write_ptr(3'd4, 10'h250, 10'h000);
        probe(26'h2500000, 4'b0000, 4'b0001, 1'b0, 1'b0, "R4 io sub 0");
        probe(26'h2504000, 4'b0000, 4'b0010, 1'b0, 1'b0, "R4 io sub 1");
        probe(26'h250BFFF, 4'b0000, 4'b0100, 1'b0, 1'b0, "R4 io sub 2");
        probe(26'h250FFFF, 4'b0000, 4'b1000, 1'b0, 1'b0, "R4 io sub 3");
        probe(26'h2510000, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 past io page misses");
    endtask

    // R7 invalid address.
    task automatic t_invalid();
        @(negedge clk);
        addr = 26'h0000000;
        addr_valid = 1'b0;
        #1;
        expect_dec(4'b0, 4'b0, 1'b0, 1'b0, "R7 valid low, mapped address");
        addr = 26'h3000000;
        #1;
        expect_dec(4'b0, 4'b0, 1'b0, 1'b0, "R7 valid low, unmapped address");
    endtask

    // R8 write and decode in the same cycle.
    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_base = 10'h280; wr_end = 10'h290;
        addr = 26'h2800000; addr_valid = 1'b1;
        #1;
        expect_dec(4'b0000, 4'b0, 1'b0, 1'b1, "R8 old map before the edge");
        @(posedge clk);
        #1;
        expect_dec(4'b0100, 4'b0, 1'b0, 1'b0, "R8 new map after the edge");
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R9 unused write indices.
    task automatic t_bad_index();
        write_ptr(3'd6, 10'h260, 10'h270);
        probe(26'h2600000, 4'b0000, 4'b0, 1'b0, 1'b1, "R9 index 6 maps nothing");
        write_ptr(3'd7, 10'h000, 10'h000);
        probe(26'h0000000, 4'b0001, 4'b0, 1'b0, 1'b0, "R9 index 7 leaves bank0");
        probe(26'h3FF0000, 4'b0000, 4'b0, 1'b1, 1'b0, "R9 index 7 leaves SFR");
        probe(26'h2800000, 4'b0100, 4'b0, 1'b0, 1'b0, "R9 index 6 leaves bank2");
        expect_ovl(1'b0, "R9 map unchanged, no overlap");
    endtask

    // R10 overlap plus R5 priority.
    task automatic t_overlap_priority();
        write_ptr(3'd3, 10'h220, 10'h260);
        expect_ovl(1'b1, "R10 bank3 over bank1 and io");
        probe(26'h2300000, 4'b0010, 4'b0, 1'b0, 1'b0, "R5 lower bank wins");
        probe(26'h2500000, 4'b1000, 4'b0, 1'b0, 1'b0, "R5 bank wins over io");
        probe(26'h2540000, 4'b1000, 4'b0, 1'b0, 1'b0, "R1 bank3 alone");
        write_ptr(3'd5, 10'h225, 10'h000);
        probe(26'h2250000, 4'b0000, 4'b0, 1'b1, 1'b0, "R5 SFR wins over banks");
        probe(26'h3FF0000, 4'b0000, 4'b0, 1'b0, 1'b1, "R8 SFR page moved away");
        write_ptr(3'd5, 10'h3FF, 10'h000);
        write_ptr(3'd3, 10'h300, 10'h310);
        expect_ovl(1'b0, "R10 flag clears when windows separate");
        probe(26'h3000000, 4'b1000, 4'b0, 1'b0, 1'b0, "R8 bank3 relocated");
        probe(26'h3100000, 4'b0000, 4'b0, 1'b0, 1'b1, "R1 bank3 end exclusive");
        write_ptr(3'd4, 10'h000, 10'h000);
        probe(26'h0000000, 4'b0001, 4'b0, 1'b0, 1'b0, "R4 io pointer zero, page 0 is bank0");
        probe(26'h2500000, 4'b0000, 4'b0, 1'b0, 1'b1, "R4 io pointer zero unmaps");
        write_ptr(3'd2, 10'h3FE, 10'h3FF);
        expect_ovl(1'b0, "R10 bank touching SFR page is apart");
        write_ptr(3'd2, 10'h3FE, 10'h3FF);
        write_ptr(3'd5, 10'h3FE, 10'h000);
        expect_ovl(1'b1, "R10 SFR inside bank2");
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        do_reset();
        t_reset_map();
        t_program_bank();
        t_empty_bank();
        t_io_region();
        t_invalid();
        t_same_cycle();
        t_bad_index();
        t_overlap_priority();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule